// File: doc/BRIEF.md
# Configuration Image Length Scanner

This block watches the opening bytes read back from offset 0 of a configuration flash and pulls out the length of the stored configuration image. The bytes arrive already bit-reversed, one per accepted handshake beat. A one-cycle start pulse arms a new scan. The scanner passes over leading 0xFF fill until it sees the 0x6A sync byte. It then steps over the four bytes that follow, which it does not interpret. The next four bytes form a 32-bit bit count, least significant byte first. The scanner rounds that count up to whole bytes and reports it.

The scan looks at no more than 128 bytes. If a byte other than fill or sync shows up before the sync byte, the result is unknown and the size is reported as zero. The same happens if the sync byte comes too late for its eight trailing bytes to fit in the window. When the scan ends, a single-cycle done pulse marks the result. The status and size then hold, and the input is not accepted, until the next start pulse.

Top module: `cfg_len_scan`

## Requirements
- R1: After reset, status is 2'b00 (idle), done is 0, size is 0 and ready is 0.
- R2: A start pulse sets status to 2'b01 (scanning) and size to 0, and raises ready on the next cycle. A start pulse during a scan discards the bytes seen so far and restarts at byte index 0. A byte offered in the same cycle as start is dropped.
- R3: Bytes equal to 0xFF that come before the sync byte are skipped.
- R4: The first byte equal to 0x6A at index 0..119 is the sync byte. The four bytes after it are ignored, whatever their values, including 0x6A and 0xFF. The bytes at sync+5, +6, +7 and +8 form the bit count, with sync+5 as bits 7:0 and sync+8 as bits 31:24.
- R5: When the byte at sync+8 is accepted, status becomes 2'b10 (found) and size becomes (bit count + 7) >> 3. The sum is taken 33 bits wide, so a count of 0xFFFFFFFF gives 0x20000000.
- R6: A byte at index 0..119 that is neither 0xFF nor 0x6A, seen before the sync byte, ends the scan with status 2'b11 (unknown) and size 0.
- R7: A byte accepted at index 120 or later while the scanner is still looking for sync ends the scan as unknown with size 0, whatever its value.
- R8: done is high for exactly one cycle, in the cycle after the scan's final byte is accepted. From then on, ready is 0, and the status and size hold through any further input until the next start pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| scan_start | input | 1 | Single-cycle pulse that begins a new scan |
| byte_valid | input | 1 | Input byte is present |
| byte_data | input | 8 | Flash byte, already bit-reversed |
| byte_ready | output | 1 | Scanner accepts a byte this cycle |
| done | output | 1 | One-cycle pulse when the result is ready |
| status | output | 2 | 00 idle, 01 scanning, 10 found, 11 unknown |
| byte_count | output | 32 | Image size in bytes; 0 unless found |

## Verification
The hardest cases to reach are at the edge of the window. One is a sync byte at index 119, the last place where it still counts; the other is the same byte one position later. Reaching them takes 119 or 120 fill bytes ahead of the sync. The bench builds those streams itself and also sends an unbroken run of 121 fill bytes. A mid-scan restart is covered too: a partial header is abandoned and then a clean one is sent. This shows that no offset state carries over.

// File: rtl/cfg_len_scan.sv
module cfg_len_scan #(
  parameter int WINDOW    = 128,
  parameter int SKIP      = 4,
  parameter int LEN_BYTES = 4,
  parameter logic [7:0] SYNC = 8'h6A,
  parameter logic [7:0] PAD  = 8'hFF
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     scan_start,
  input  logic                     byte_valid,
  input  logic [7:0]               byte_data,
  output logic                     byte_ready,
  output logic                     done,
  output logic [1:0]               status,
  output logic [8*LEN_BYTES-1:0]   byte_count
);
  localparam int CW        = 8 * LEN_BYTES;
  localparam int IW        = $clog2(WINDOW + 1);
  localparam int HW        = $clog2(SKIP + LEN_BYTES + 1);
  localparam int LAST_SYNC = WINDOW - 1 - SKIP - LEN_BYTES;
  localparam int LAST_HDR  = SKIP + LEN_BYTES - 1;

  typedef enum logic [1:0] {IDLE, HUNT, HDR, FIN} st_t;

  st_t            st;
  logic [IW-1:0]  idx;
  logic [HW-1:0]  hcnt;
  logic [CW-1:0]  bits;
  logic           miss;

  wire            take    = byte_valid && byte_ready && !scan_start;
  wire [CW-1:0]   bits_nx = {byte_data, bits[CW-1:8]};
  wire [CW:0]     sum     = {1'b0, bits_nx} + (CW+1)'(7);

  assign byte_ready = (st == HUNT) || (st == HDR);
  assign status = (st == IDLE) ? 2'b00 :
                  (st == FIN)  ? {1'b1, miss} : 2'b01;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= IDLE;
      idx        <= '0;
      hcnt       <= '0;
      bits       <= '0;
      miss       <= 1'b0;
      done       <= 1'b0;
      byte_count <= '0;
    end else begin
      done <= 1'b0;
      if (scan_start) begin
        st         <= HUNT;
        idx        <= '0;
        hcnt       <= '0;
        bits       <= '0;
        miss       <= 1'b0;
        byte_count <= '0;
      end else if (take) begin
        idx <= idx + 1'b1;
        if (st == HUNT) begin
          if (idx > IW'(LAST_SYNC) || (byte_data != SYNC && byte_data != PAD)) begin
            st   <= FIN;
            miss <= 1'b1;
            done <= 1'b1;
          end else if (byte_data == SYNC) begin
            st <= HDR;
          end
        end else begin
          hcnt <= hcnt + 1'b1;
          if (hcnt >= HW'(SKIP)) bits <= bits_nx;
          if (hcnt == HW'(LAST_HDR)) begin
            st         <= FIN;
            done       <= 1'b1;
            byte_count <= sum[CW:3];
          end
        end
      end
    end
  end
endmodule

module cfg_len_scan_chk #(
  parameter int CW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          scan_start,
  input logic          byte_ready,
  input logic          done,
  input logic [1:0]    status,
  input logic [CW-1:0] byte_count
);
  p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_result_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> status[1]);
  p_unknown_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (status == 2'b11) |-> (byte_count == '0));
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (status[1] && !scan_start) |=> ($stable(byte_count) && $stable(status) && !done));
  p_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
    byte_ready |-> (status == 2'b01));
  p_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    scan_start |=> (status == 2'b01 && byte_count == '0 && !done));
endmodule

bind cfg_len_scan cfg_len_scan_chk #(.CW(8*LEN_BYTES)) u_chk (
  .clk(clk), .rst_n(rst_n), .scan_start(scan_start), .byte_ready(byte_ready),
  .done(done), .status(status), .byte_count(byte_count));

// File: tb/cfg_len_scan_test.sv
module cfg_len_scan_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        scan_start = 0;
  logic        byte_valid = 0;
  logic [7:0]  byte_data = 0;
  logic        byte_ready, done;
  logic [1:0]  status;
  logic [31:0] byte_count;
  int checks = 0;
  int fails = 0;

  cfg_len_scan uut (.*);

  always #10 clk = ~clk;

  localparam int NV = 8;
  localparam int          V_PAD [NV] = '{0, 3, 10, 1, 119, 0, 50, 7};
  localparam logic [31:0] V_BITS[NV] = '{32'd0, 32'd8, 32'd9, 32'h12345,
                                         32'd1, 32'hFFFFFFFF, 32'd16, 32'd23};
  localparam logic [31:0] V_EXP [NV] = '{32'd0, 32'd1, 32'd2, 32'd9321,
                                         32'd1, 32'h20000000, 32'd2, 32'd3};

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic start_scan();
    @(negedge clk) scan_start = 1;
    @(negedge clk) scan_start = 0;
  endtask

  task automatic send(input logic [7:0] b);
    @(negedge clk) begin byte_valid = 1; byte_data = b; end
    @(posedge clk);
    @(negedge clk) byte_valid = 0;
  endtask

  task automatic send_header(input int pads, input logic [31:0] bits);
    for (int i = 0; i < pads; i++) send(8'hFF);
    send(8'h6A);
    send(8'h6A); send(8'hFF); send(8'h00); send(8'h55);
    for (int i = 0; i < 4; i++) send(bits[8*i +: 8]);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(status == 2'b00 && !done && byte_count == 0 && !byte_ready, "R1", {28'd0, status, done, byte_ready}, 0);
    rst_n = 1;

    start_scan();
    chk(status == 2'b01 && byte_ready && byte_count == 0, "R2", {30'd0, status}, 1);

    for (int v = 0; v < NV; v++) begin
      start_scan();
      send_header(V_PAD[v], V_BITS[v]);
      chk(done && status == 2'b10, "R4", {30'd0, status}, 2);
      chk(byte_count == V_EXP[v], (v == 5) ? "R5" : "R3", byte_count, V_EXP[v]);
      @(negedge clk);
      chk(!done, "R8", done, 0);
    end

    start_scan();
    send(8'h00);
    chk(done && status == 2'b11 && byte_count == 0, "R6", {30'd0, status}, 3);

    start_scan();
    for (int i = 0; i < 5; i++) send(8'hFF);
    send(8'h12);
    chk(done && status == 2'b11, "R6", {30'd0, status}, 3);

    start_scan();
    for (int i = 0; i < 120; i++) send(8'hFF);
    chk(status == 2'b01 && !done, "R7", {30'd0, status}, 1);
    send(8'h6A);
    chk(done && status == 2'b11 && byte_count == 0, "R7", {30'd0, status}, 3);

    start_scan();
    for (int i = 0; i < 121; i++) send(8'hFF);
    chk(done && status == 2'b11, "R7", {30'd0, status}, 3);

    start_scan();
    send_header(2, 32'd40);
    @(negedge clk);
    chk(!byte_ready, "R8", byte_ready, 0);
    send(8'h6A); send(8'h11); send(8'h22);
    chk(status == 2'b10 && byte_count == 5 && !done, "R8", byte_count, 5);

    start_scan();
    send(8'hFF); send(8'h6A); send(8'h01); send(8'h02);
    start_scan();
    chk(status == 2'b01 && byte_count == 0, "R2", {30'd0, status}, 1);
    send_header(0, 32'd64);
    chk(done && status == 2'b10 && byte_count == 8, "R2", byte_count, 8);

    @(negedge clk) begin scan_start = 1; byte_valid = 1; byte_data = 8'h00; end
    @(negedge clk) begin scan_start = 0; byte_valid = 0; end
    chk(status == 2'b01 && !done, "R2", {30'd0, status}, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule